// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit down-counting timer channel with an 8-bit processor register interface. A two-bit address selects one of three counter ports or a write-only control port. The channel answers on the counter port given by its `CHAN_ID` parameter and on the control port. An active-low chip select qualifies the active-low read and write strobes. An access takes effect on the first system clock where its strobe is seen low after being high.

Software first writes a control word. The control word picks the byte format and clears the byte pointers. Software then writes the initial count through a staging register. The staged count is copied into the counting element as a single 16-bit transfer on the next count tick. The counting element cannot be reached directly. Reads return either the live count or a copy frozen by a latch command. A status byte can also be latched, and it is read out ahead of the count. Every mode code behaves as a rate generator. `cnt_tick` is a one-cycle enable that marks a rising edge of the counting clock, and `gate` level-enables counting.

Top module: `timer_channel`

## Requirements
- R1: After reset `out` is 1 and `dout` is 0x00. Until a control word has been accepted, writes to the counter port are ignored. Until then, a count read returns 0x00.
- R2: While `cs_n` is high, both reads and writes are ignored, and `dout` keeps its value.
- R3: A control word takes effect only when its bits 7:6 equal `CHAN_ID` or equal 11. A count is accepted only at address `CHAN_ID`. A read at address 11 leaves `dout` unchanged.
- R4: Control word bits 5:4 set the byte format: 01 is low byte only, 10 is high byte only and 11 is low then high. In either single-byte format, the byte that is not written becomes zero in the staged count.
- R5: In the low-then-high format, the count is transferred only after its high byte is written. Bit 6 of the status byte (null count) is set by a control word and by a completed count write. It is cleared on the tick that performs the transfer.
- R6: With `gate` high, each tick decrements the count. The tick that takes the count from 2 to 1 drives `out` low. The next tick reloads the staged count and drives `out` high, so an initial count of N gives a period of N ticks. With `gate` low, neither the count nor `out` changes.
- R7: An initial count of 0 gives a period of 65536 ticks. `out` goes low on the 65535th tick after the transfer.
- R8: A control word with bits 5:4 = 00 latches the count. Reads return the latched bytes until the last byte of the format has been read. After that, reads follow the live count.
- R9: A latch command issued while a latched count is still unread has no effect.
- R10: A control word with bits 7:6 = 11 latches a status byte. The status byte holds `out` in bit 7, null count in bit 6, the format in bits 5:4, the mode in bits 3:1 and the BCD bit in bit 0. The next read returns this byte before any count byte. A second status latch issued before that read is ignored.
- R11: In the low-then-high format, successive count reads return the low byte and then the high byte.
- R12: A control word with a nonzero format clears the write byte pointer. The next count byte is therefore taken as the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Port select: counter 0, 1, 2 or control (11) |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data |
| cnt_tick | input | 1 | One-cycle enable marking a counting-clock edge |
| gate | input | 1 | Count enable level |
| out | output | 1 | Registered timer output |

## Verification
A strobe is acted on at the first clock edge at which it is low. Any register it changes, including `dout`, holds its new value from that edge onward. The bench therefore samples one falling edge after releasing the strobe. A completed count write raises an internal request at its edge and arms the transfer at the following edge. For this reason the bench idles two cycles before it issues the tick that transfers the count. `out` and the count change at the edge of each tick, and the bench checks `out` at the falling edge that follows each tick. Counts are read only after ticking has stopped, so every expected byte is fixed when it is sampled.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    FMT_NONE = 2'b00,
    FMT_LO   = 2'b01,
    FMT_HI   = 2'b10,
    FMT_LH   = 2'b11
  } fmt_e;

  localparam logic [1:0] SEL_STATUS = 2'b11;
  localparam logic [1:0] CTRL_ADDR  = 2'b11;
endpackage

// File: rtl/timer_bus_sync.sv
module timer_bus_sync #(
  parameter int ADDR_W  = 2,
  parameter int CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              ctl_fire,
  output logic              cnt_wr_fire,
  output logic              cnt_rd_fire
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CHAN_ID);
  localparam logic [ADDR_W-1:0] CTL_ADDR = {ADDR_W{1'b1}};

  logic rd_q, wr_q;
  logic rd_edge, wr_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b1;
      wr_q <= 1'b1;
    end else begin
      rd_q <= rd_n;
      wr_q <= wr_n;
    end
  end

  assign rd_edge     = !cs_n && !rd_n && rd_q;
  assign wr_edge     = !cs_n && !wr_n && wr_q;
  assign ctl_fire    = wr_edge && (addr == CTL_ADDR);
  assign cnt_wr_fire = wr_edge && (addr == MY_ADDR);
  assign cnt_rd_fire = rd_edge && (addr == MY_ADDR);
endmodule

// File: rtl/timer_count_core.sv
module timer_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_tick,
  input  logic             gate,
  input  logic             mode_wr,
  input  logic             load_req,
  input  logic [CNT_W-1:0] stage,
  output logic [CNT_W-1:0] count,
  output logic             out,
  output logic             null_cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic pend;
  logic run;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      out      <= 1'b1;
      null_cnt <= 1'b0;
      pend     <= 1'b0;
      run      <= 1'b0;
    end else if (mode_wr) begin
      out      <= 1'b1;
      null_cnt <= 1'b1;
      pend     <= 1'b0;
      run      <= 1'b0;
    end else begin
      if (cnt_tick && pend) begin
        count    <= stage;
        pend     <= 1'b0;
        null_cnt <= 1'b0;
        run      <= 1'b1;
        out      <= 1'b1;
      end else if (cnt_tick && gate && run) begin
        if (count == ONE) begin
          count <= stage;
          out   <= 1'b1;
        end else begin
          count <= count - ONE;
          if (count == TWO) out <= 1'b0;
        end
      end
      if (load_req) begin
        pend     <= 1'b1;
        null_cnt <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/timer_readout.sv
module timer_readout
  import timer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*BYTE_W-1:0] count,
  input  logic [BYTE_W-1:0]   status_in,
  input  fmt_e                fmt,
  input  logic                latch_cmd,
  input  logic                status_cmd,
  input  logic                mode_wr,
  input  logic                rd_fire,
  output logic [BYTE_W-1:0]   dout
);
  logic [2*BYTE_W-1:0] hold_val;
  logic [2*BYTE_W-1:0] view;
  logic                hold_on;
  logic [BYTE_W-1:0]   stat;
  logic                stat_on;
  logic                rd_hi;

  assign view = hold_on ? hold_val : count;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_val <= '0;
      hold_on  <= 1'b0;
      stat     <= '0;
      stat_on  <= 1'b0;
      rd_hi    <= 1'b0;
      dout     <= '0;
    end else begin
      if (latch_cmd && !hold_on) begin
        hold_val <= count;
        hold_on  <= 1'b1;
      end
      if (status_cmd && !stat_on) begin
        stat    <= status_in;
        stat_on <= 1'b1;
      end
      if (mode_wr) begin
        rd_hi   <= 1'b0;
        hold_on <= 1'b0;
      end
      if (rd_fire) begin
        if (stat_on) begin
          dout    <= stat;
          stat_on <= 1'b0;
        end else begin
          unique case (fmt)
            FMT_LO: begin
              dout    <= view[BYTE_W-1:0];
              hold_on <= 1'b0;
            end
            FMT_HI: begin
              dout    <= view[2*BYTE_W-1:BYTE_W];
              hold_on <= 1'b0;
            end
            FMT_LH: begin
              if (!rd_hi) begin
                dout  <= view[BYTE_W-1:0];
                rd_hi <= 1'b1;
              end else begin
                dout    <= view[2*BYTE_W-1:BYTE_W];
                rd_hi   <= 1'b0;
                hold_on <= 1'b0;
              end
            end
            default: dout <= '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int ADDR_W  = 2,
  parameter int CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout,
  input  logic              cnt_tick,
  input  logic              gate,
  output logic              out
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [1:0] MY_SEL = 2'(CHAN_ID);

  logic ctl_fire, cnt_wr_fire, cnt_rd_fire;
  logic mode_wr, latch_cmd, status_cmd;
  fmt_e fmt;
  logic [2:0] mode;
  logic bcd;
  logic wr_hi;
  logic load_req;
  logic [CNT_W-1:0] stage;
  logic [CNT_W-1:0] count;
  logic null_cnt;
  logic [BYTE_W-1:0] status_byte;

  timer_bus_sync #(.ADDR_W(ADDR_W), .CHAN_ID(CHAN_ID)) u_bus (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .ctl_fire(ctl_fire), .cnt_wr_fire(cnt_wr_fire), .cnt_rd_fire(cnt_rd_fire)
  );

  assign mode_wr    = ctl_fire && (din[7:6] == MY_SEL) && (din[5:4] != 2'b00);
  assign latch_cmd  = ctl_fire && (din[7:6] == MY_SEL) && (din[5:4] == 2'b00);
  assign status_cmd = ctl_fire && (din[7:6] == SEL_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt      <= FMT_NONE;
      mode     <= '0;
      bcd      <= 1'b0;
      wr_hi    <= 1'b0;
      stage    <= '0;
      load_req <= 1'b0;
    end else begin
      load_req <= 1'b0;
      if (mode_wr) begin
        fmt   <= fmt_e'(din[5:4]);
        mode  <= din[3:1];
        bcd   <= din[0];
        wr_hi <= 1'b0;
      end else if (cnt_wr_fire) begin
        unique case (fmt)
          FMT_LO: begin
            stage    <= {{BYTE_W{1'b0}}, din};
            load_req <= 1'b1;
          end
          FMT_HI: begin
            stage    <= {din, {BYTE_W{1'b0}}};
            load_req <= 1'b1;
          end
          FMT_LH: begin
            if (!wr_hi) begin
              stage[BYTE_W-1:0] <= din;
              wr_hi             <= 1'b1;
            end else begin
              stage[CNT_W-1:BYTE_W] <= din;
              wr_hi                 <= 1'b0;
              load_req              <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  timer_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .gate(gate), .mode_wr(mode_wr),
    .load_req(load_req), .stage(stage), .count(count), .out(out), .null_cnt(null_cnt)
  );

  assign status_byte = BYTE_W'({out, null_cnt, fmt, mode, bcd});

  timer_readout #(.BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst(rst), .count(count), .status_in(status_byte), .fmt(fmt),
    .latch_cmd(latch_cmd), .status_cmd(status_cmd), .mode_wr(mode_wr),
    .rd_fire(cnt_rd_fire), .dout(dout)
  );
endmodule

// File: rtl/timer_channel_chk.sv
module timer_channel_chk #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              rd_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] dout,
  input logic              cnt_tick,
  input logic              gate,
  input logic              out
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d && !rst) begin
      assert_reset_state_R1: assert (out == 1'b1 && dout == '0)
        else $error("R1 reset state wrong");
    end
  end

  assert_cs_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable(dout));

  assert_ctrl_read_R3: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && addr == {ADDR_W{1'b1}}) |=> $stable(dout));

  assert_pulse_one_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (!out && cnt_tick && gate) |=> out);

  assert_fall_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (out && !cnt_tick) |=> out);

  assert_gate_low_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (out && !gate) |=> out);
endmodule

bind timer_channel timer_channel_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .addr(addr), .dout(dout),
  .cnt_tick(cnt_tick), .gate(gate), .out(out)
);

// File: tb/sim_timer_channel.sv
module sim_timer_channel;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic cnt_tick = 1'b0, gate = 1'b0;
  logic out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  timer_channel #(.BYTE_W(8), .ADDR_W(2), .CHAN_ID(0)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .din(din), .dout(dout), .cnt_tick(cnt_tick), .gate(gate), .out(out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic cs, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = cs; wr_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic rd(input logic cs, input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    cs_n = cs; rd_n = 1'b0; addr = a;
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
    v = dout;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick1();
    cnt_tick = 1'b1;
    @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic load_count(input logic [7:0] lo, input logic [7:0] hi);
    wr(1'b0, 2'b00, lo);
    wr(1'b0, 2'b00, hi);
    idle(2);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 out after reset", {7'b0, out}, 8'h01);
    chk("R1 dout after reset", dout, 8'h00);
    gate = 1'b1;
    wr(1'b0, 2'b00, 8'h02);
    idle(2);
    for (int k = 0; k < 4; k++) begin
      tick1();
      chk("R1 unprogrammed out", {7'b0, out}, 8'h01);
    end
    rd(1'b0, 2'b00, v);
    chk("R1 unprogrammed read", v, 8'h00);
    gate = 1'b0;
  endtask

  task automatic t_cs();
    logic [7:0] v;
    wr(1'b1, 2'b11, 8'h34);
    wr(1'b0, 2'b11, 8'hC0);
    rd(1'b1, 2'b00, v);
    chk("R2 read without select", v, 8'h00);
    rd(1'b0, 2'b00, v);
    chk("R2 control write without select ignored", v, 8'h80);
  endtask

  task automatic t_decode();
    logic [7:0] v;
    wr(1'b0, 2'b11, 8'h74);
    wr(1'b0, 2'b11, 8'hC0);
    rd(1'b0, 2'b00, v);
    chk("R3 other-channel control ignored", v, 8'h80);
    wr(1'b0, 2'b11, 8'h34);
    wr(1'b0, 2'b11, 8'hC0);
    rd(1'b0, 2'b00, v);
    chk("R10 status after control word", v, 8'hF4);
    rd(1'b0, 2'b11, v);
    chk("R3 control port read", v, 8'hF4);
  endtask

  task automatic t_lh_rate();
    logic [7:0] v;
    gate = 1'b1;
    wr(1'b0, 2'b00, 8'h04);
    idle(2);
    tick1();
    wr(1'b0, 2'b11, 8'hC0);
    rd(1'b0, 2'b00, v);
    chk("R5 no transfer after low byte", v, 8'hF4);
    wr(1'b0, 2'b00, 8'h00);
    idle(2);
    tick1();
    wr(1'b0, 2'b11, 8'hC0);
    rd(1'b0, 2'b00, v);
    chk("R5 null cleared by transfer", v, 8'hB4);
    rd(1'b0, 2'b00, v);
    chk("R11 low byte", v, 8'h04);
    rd(1'b0, 2'b00, v);
    chk("R11 high byte", v, 8'h00);
    wr(1'b0, 2'b01, 8'h09);
    wr(1'b0, 2'b01, 8'h00);
    idle(2);
    wr(1'b0, 2'b11, 8'hC0);
    rd(1'b0, 2'b00, v);
    chk("R3 other counter port ignored", v, 8'hB4);
    for (int k = 1; k <= 8; k++) begin
      tick1();
      chk("R6 rate output", {7'b0, out}, (k == 3 || k == 7) ? 8'h00 : 8'h01);
    end
    gate = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick1();
      chk("R6 gate low output", {7'b0, out}, 8'h01);
    end
    rd(1'b0, 2'b00, v);
    chk("R6 gate low count lo", v, 8'h04);
    rd(1'b0, 2'b00, v);
    chk("R6 gate low count hi", v, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] v;
    wr(1'b0, 2'b11, 8'h00);
    gate = 1'b1;
    tick1();
    gate = 1'b0;
    rd(1'b0, 2'b00, v);
    chk("R8 latched lo", v, 8'h04);
    rd(1'b0, 2'b00, v);
    chk("R8 latched hi", v, 8'h00);
    rd(1'b0, 2'b00, v);
    chk("R8 follows after read", v, 8'h03);
    rd(1'b0, 2'b00, v);
    chk("R8 follows hi", v, 8'h00);
  endtask

  task automatic t_relatch();
    logic [7:0] v;
    wr(1'b0, 2'b11, 8'h34);
    load_count(8'h34, 8'h12);
    gate = 1'b0;
    tick1();
    wr(1'b0, 2'b11, 8'h00);
    gate = 1'b1;
    tick1();
    tick1();
    gate = 1'b0;
    wr(1'b0, 2'b11, 8'h00);
    rd(1'b0, 2'b00, v);
    chk("R9 first latch kept lo", v, 8'h34);
    rd(1'b0, 2'b00, v);
    chk("R9 R11 first latch kept hi", v, 8'h12);
    rd(1'b0, 2'b00, v);
    chk("R8 live lo", v, 8'h32);
    rd(1'b0, 2'b00, v);
    chk("R8 live hi", v, 8'h12);
  endtask

  task automatic t_formats();
    logic [7:0] v;
    wr(1'b0, 2'b11, 8'h14);
    wr(1'b0, 2'b00, 8'h03);
    idle(2);
    gate = 1'b1;
    tick1();
    for (int k = 1; k <= 3; k++) begin
      tick1();
      chk("R4 low-only high byte zero", {7'b0, out}, (k == 2) ? 8'h00 : 8'h01);
    end
    wr(1'b0, 2'b11, 8'h24);
    wr(1'b0, 2'b00, 8'h01);
    idle(2);
    gate = 1'b0;
    tick1();
    rd(1'b0, 2'b00, v);
    chk("R4 high-only read", v, 8'h01);
    gate = 1'b1;
    tick1();
    gate = 1'b0;
    rd(1'b0, 2'b00, v);
    chk("R4 high-only low byte zero", v, 8'h00);
  endtask

  task automatic t_ptr();
    wr(1'b0, 2'b11, 8'h34);
    wr(1'b0, 2'b00, 8'h07);
    wr(1'b0, 2'b11, 8'h34);
    load_count(8'h02, 8'h00);
    gate = 1'b1;
    tick1();
    for (int k = 1; k <= 2; k++) begin
      tick1();
      chk("R12 pointer reset period", {7'b0, out}, (k == 1) ? 8'h00 : 8'h01);
    end
    gate = 1'b0;
  endtask

  task automatic t_status();
    logic [7:0] v;
    wr(1'b0, 2'b11, 8'h34);
    wr(1'b0, 2'b11, 8'hC0);
    load_count(8'h05, 8'h00);
    tick1();
    wr(1'b0, 2'b11, 8'hC0);
    rd(1'b0, 2'b00, v);
    chk("R10 second status latch ignored", v, 8'hF4);
    rd(1'b0, 2'b00, v);
    chk("R10 count after status lo", v, 8'h05);
    rd(1'b0, 2'b00, v);
    chk("R10 count after status hi", v, 8'h00);
  endtask

  task automatic t_zero();
    wr(1'b0, 2'b11, 8'h34);
    load_count(8'h00, 8'h00);
    gate = 1'b1;
    cnt_tick = 1'b1;
    @(negedge clk);
    for (int k = 1; k <= 65536; k++) begin
      @(negedge clk);
      if (k == 65534) chk("R7 high before end", {7'b0, out}, 8'h01);
      if (k == 65535) chk("R7 low at 65535", {7'b0, out}, 8'h00);
      if (k == 65536) chk("R7 reload at 65536", {7'b0, out}, 8'h01);
    end
    cnt_tick = 1'b0;
    gate = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cs();
    t_decode();
    t_lh_rate();
    t_latch();
    t_relatch();
    t_formats();
    t_ptr();
    t_status();
    t_zero();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule